// File: doc/BRIEF.md
# Serial Flash Read and Identification Responder

This block is the target side of a single-bit serial flash link. The host drives the link in clock mode 0 or mode 3. The block serves byte reads and identity queries from a small read-only store that lives on chip. The serial clock, select and data-in pins are brought into the system clock domain through synchronizers. The block finds the serial clock edges there, so the link must run several times slower than the system clock.

A command starts with an 8-bit opcode. Some opcodes then take a 24-bit address or filler field, and one also takes 8 filler clocks. After that the block sends its reply bytes for as long as select stays low. Read replies come from the store, and the address steps on after each byte. Identity replies cycle through a fixed set of bytes. A low-power state can be entered by command. While in it, the block answers only the wake-up command.

The store holds MEM_BYTES bytes, and MEM_BYTES must be a power of two. The content at index i is the low byte of (i*29 + 60) XOR (i >> 3).

Top module: `spi_flash_rd_resp`

## Requirements
- R1: Opcode, address and filler bits are taken from `mosi` on rising `sclk` edges, most significant bit first. With select low and the clock idling high (mode 3), the first falling edge carries no meaning.
- R2: `miso` changes only after a falling `sclk` edge. Each reply byte is sent most significant bit first, and the first bit appears on the falling edge after the last bit of the command.
- R3: `miso_oe` is 0 whenever `cs_n` is high, during the opcode and address phases, and for any ignored command. It is 1 during every reply bit of an accepted command.
- R4: Opcode 03h takes a 24-bit address and then returns store bytes starting at that address.
- R5: Opcode 0Bh takes a 24-bit address and then 8 filler clocks before the store bytes start.
- R6: The read index is the low log2(MEM_BYTES) address bits, so higher bits are ignored. The index rises by one after each byte and wraps from MEM_BYTES-1 to 0.
- R7: Opcode 9Fh returns, with no address, the bytes MFR_ID (EFh), MEM_TYPE (40h) and CAP_ID (14h), and repeats them in that order.
- R8: Opcode 90h takes 24 address bits (host sends 000000h) and then returns MFR_ID and DEV_ID (13h) alternately.
- R9: Opcode ABh takes 24 filler bits and then returns DEV_ID repeatedly. When the opcode byte completes, it also ends the low-power state.
- R10: Opcode B9h puts the block into the low-power state when select next rises. In that state, every opcode other than ABh is ignored.
- R11: Any other opcode is ignored until select rises.
- R12: After reset the block is out of the low-power state and `miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select from the host |
| mosi | input | 1 | Serial data in from the host |
| miso | output | 1 | Serial data out to the host |
| miso_oe | output | 1 | Output enable for the data-out pad (0 = high impedance) |

## Verification
Four properties are checked on every cycle:
- the data-out level stays put between falling clock edges;
- the enable drops once select is high;
- the preamble counter stays inside the length chosen for the opcode;
- the low-power state is entered only while deselected, and no address or reply phase runs while it holds.

Some behaviour is only shown by bench transactions: the byte values of the store and identity replies, the filler clock counts, index wrap and aliasing, mode 3 framing, and the ignoring and wake-up order around the low-power state.

// File: rtl/spi_flash_rd_pkg.sv
package spi_flash_rd_pkg;

  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_FAST   = 8'h0B;
  localparam logic [7:0] OP_JEDEC  = 8'h9F;
  localparam logic [7:0] OP_MFDEV  = 8'h90;
  localparam logic [7:0] OP_WAKE   = 8'hAB;
  localparam logic [7:0] OP_SLEEP  = 8'hB9;

  localparam logic [5:0] ADDR_BITS = 6'd24;
  localparam logic [5:0] FAST_BITS = 6'd32;

  typedef enum logic [1:0] {
    ST_OPC    = 2'd0,
    ST_PRE    = 2'd1,
    ST_STREAM = 2'd2,
    ST_IGNORE = 2'd3
  } fsm_st_e;

  typedef enum logic [1:0] {
    SRC_MEM   = 2'd0,
    SRC_JEDEC = 2'd1,
    SRC_MFDEV = 2'd2,
    SRC_DEVID = 2'd3
  } src_e;

  // Store content: low byte of (i*29 + 60) xor (i >> 3)
  function automatic logic [7:0] rom_byte(input logic [23:0] idx);
    logic [23:0] t;
    t = idx * 24'd29 + 24'd60;
    return t[7:0] ^ idx[10:3];
  endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_hi,
  output logic cs_rise,
  output logic mosi_s
);

  // bit 2 = select, bit 1 = clock, bit 0 = data
  localparam logic [2:0] IDLE_VAL = 3'b100;

  logic [2:0] stg_q [STAGES];
  logic [2:0] last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= IDLE_VAL;
          else        stg_q[g] <= {cs_n, sclk, mosi};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= IDLE_VAL;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IDLE_VAL;
    else        last_q <= stg_q[STAGES-1];
  end

  assign sclk_rise = stg_q[STAGES-1][1] & ~last_q[1];
  assign sclk_fall = ~stg_q[STAGES-1][1] & last_q[1];
  assign cs_hi     = stg_q[STAGES-1][2];
  assign cs_rise   = stg_q[STAGES-1][2] & ~last_q[2];
  assign mosi_s    = stg_q[STAGES-1][0];

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import spi_flash_rd_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          cs_hi,
  input  logic          cs_rise,
  input  logic          mosi_s,
  output logic          stream,
  output src_e          src,
  output logic [AW-1:0] start_idx,
  output logic          pd
);

  fsm_st_e       state_q, state_n;
  logic [5:0]    cnt_q, cnt_n;
  logic [5:0]    len_q, len_n;
  logic [7:0]    op_q, op_n;
  logic [AW-1:0] addr_q, addr_n;
  src_e          src_q, src_n;
  logic          pd_q, pd_n;
  logic          arm_q, arm_n;
  logic [7:0]    op_w;

  assign op_w = {op_q[6:0], mosi_s};

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    len_n   = len_q;
    op_n    = op_q;
    addr_n  = addr_q;
    src_n   = src_q;
    pd_n    = pd_q;
    arm_n   = arm_q;
    if (cs_hi) begin
      state_n = ST_OPC;
      cnt_n   = '0;
      arm_n   = 1'b0;
      if (cs_rise && arm_q) pd_n = 1'b1;
    end else if (rise) begin
      unique case (state_q)
        ST_OPC: begin
          op_n  = op_w;
          cnt_n = cnt_q + 6'd1;
          if (cnt_q == 6'd7) begin
            cnt_n = '0;
            if (pd_q && op_w != OP_WAKE) begin
              state_n = ST_IGNORE;
            end else begin
              unique case (op_w)
                OP_READ:  begin state_n = ST_PRE; len_n = ADDR_BITS; src_n = SRC_MEM;   end
                OP_FAST:  begin state_n = ST_PRE; len_n = FAST_BITS; src_n = SRC_MEM;   end
                OP_MFDEV: begin state_n = ST_PRE; len_n = ADDR_BITS; src_n = SRC_MFDEV; end
                OP_WAKE:  begin
                  state_n = ST_PRE; len_n = ADDR_BITS; src_n = SRC_DEVID; pd_n = 1'b0;
                end
                OP_JEDEC: begin state_n = ST_STREAM; src_n = SRC_JEDEC; end
                OP_SLEEP: begin state_n = ST_IGNORE; arm_n = 1'b1; end
                default:  state_n = ST_IGNORE;
              endcase
            end
          end
        end
        ST_PRE: begin
          cnt_n = cnt_q + 6'd1;
          if (cnt_q < ADDR_BITS) addr_n = {addr_q[AW-2:0], mosi_s};
          if (cnt_q == len_q - 6'd1) state_n = ST_STREAM;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPC;
      cnt_q   <= '0;
      len_q   <= ADDR_BITS;
      op_q    <= '0;
      addr_q  <= '0;
      src_q   <= SRC_MEM;
      pd_q    <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      len_q   <= len_n;
      op_q    <= op_n;
      addr_q  <= addr_n;
      src_q   <= src_n;
      pd_q    <= pd_n;
      arm_q   <= arm_n;
    end
  end

  assign stream    = (state_q == ST_STREAM);
  assign src       = src_q;
  assign start_idx = addr_q;
  assign pd        = pd_q;

  // R1: the preamble counter never runs past the length chosen for the opcode
  p_pre_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE) |-> (cnt_q < len_q));

  // R10: while asleep no address or reply phase is running
  p_pd_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> (state_q != ST_PRE && state_q != ST_STREAM));

  // R10: sleep starts only while deselected
  p_pd_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_q) |-> cs_hi);

endmodule

// File: rtl/flash_tx_shift.sv
module flash_tx_shift
  import spi_flash_rd_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter logic [7:0]  MFR_ID   = 8'hEF,
  parameter logic [7:0]  MEM_TYPE = 8'h40,
  parameter logic [7:0]  CAP_ID   = 8'h14,
  parameter logic [7:0]  DEV_ID   = 8'h13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stream,
  input  logic          fall,
  input  src_e          src,
  input  logic [AW-1:0] start_idx,
  output logic          miso
);

  logic          live_q, live_n;
  logic [2:0]    bcnt_q, bcnt_n;
  logic [7:0]    sh_q, sh_n;
  logic [AW-1:0] idx_q, idx_n;
  logic [1:0]    seq_q, seq_n, seq_adv;
  logic [7:0]    nb;

  always_comb begin
    unique case (src)
      SRC_MEM:   nb = rom_byte(24'(idx_q));
      SRC_JEDEC: nb = (seq_q == 2'd0) ? MFR_ID : ((seq_q == 2'd1) ? MEM_TYPE : CAP_ID);
      SRC_MFDEV: nb = seq_q[0] ? DEV_ID : MFR_ID;
      default:   nb = DEV_ID;
    endcase
    unique case (src)
      SRC_JEDEC: seq_adv = (seq_q == 2'd2) ? 2'd0 : seq_q + 2'd1;
      SRC_MFDEV: seq_adv = {1'b0, ~seq_q[0]};
      default:   seq_adv = 2'd0;
    endcase
  end

  always_comb begin
    live_n = stream;
    bcnt_n = bcnt_q;
    sh_n   = sh_q;
    idx_n  = idx_q;
    seq_n  = seq_q;
    if (stream && !live_q) begin
      bcnt_n = '0;
      idx_n  = start_idx;
      seq_n  = '0;
    end else if (stream && fall) begin
      bcnt_n = bcnt_q + 3'd1;
      if (bcnt_q == 3'd0) begin
        sh_n  = nb;
        seq_n = seq_adv;
        if (src == SRC_MEM) idx_n = idx_q + 1'b1;
      end else begin
        sh_n = {sh_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      bcnt_q <= '0;
      sh_q   <= '0;
      idx_q  <= '0;
      seq_q  <= '0;
    end else begin
      live_q <= live_n;
      bcnt_q <= bcnt_n;
      sh_q   <= sh_n;
      idx_q  <= idx_n;
      seq_q  <= seq_n;
    end
  end

  assign miso = sh_q[7];

  // R2: data out holds its level unless a falling serial edge was seen
  p_miso_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(miso));

endmodule

// File: rtl/spi_flash_rd_resp.sv
module spi_flash_rd_resp
  import spi_flash_rd_pkg::*;
#(
  parameter int unsigned MEM_BYTES   = 256,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  MFR_ID      = 8'hEF,
  parameter logic [7:0]  MEM_TYPE    = 8'h40,
  parameter logic [7:0]  CAP_ID      = 8'h14,
  parameter logic [7:0]  DEV_ID      = 8'h13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);

  localparam int unsigned AW = $clog2(MEM_BYTES);

  logic [1:0]    rst_pipe;
  logic          rst_s;
  logic          rise, fall, cs_hi, cs_rise, mosi_s;
  logic          stream, pd;
  src_e          src;
  logic [AW-1:0] start_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_s),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .sclk_rise (rise),
    .sclk_fall (fall),
    .cs_hi     (cs_hi),
    .cs_rise   (cs_rise),
    .mosi_s    (mosi_s)
  );

  flash_cmd_fsm #(.AW(AW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_s),
    .rise      (rise),
    .cs_hi     (cs_hi),
    .cs_rise   (cs_rise),
    .mosi_s    (mosi_s),
    .stream    (stream),
    .src       (src),
    .start_idx (start_idx),
    .pd        (pd)
  );

  flash_tx_shift #(
    .AW(AW), .MFR_ID(MFR_ID), .MEM_TYPE(MEM_TYPE), .CAP_ID(CAP_ID), .DEV_ID(DEV_ID)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_s),
    .stream    (stream),
    .fall      (fall),
    .src       (src),
    .start_idx (start_idx),
    .miso      (miso)
  );

  assign miso_oe = stream;

  // R3: one cycle after a synchronized deselect the pad is released
  p_hiz_deselect_r3: assert property (@(posedge clk) disable iff (!rst_s)
    $past(cs_hi) |-> !miso_oe);

  // R12: sleep flag and enable are both clear in the cycle after reset ends
  p_reset_state_r12: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(rst_s) |-> (!pd && !miso_oe));

endmodule

// File: tb/spi_flash_rd_resp_tb.sv
module spi_flash_rd_resp_tb;

  localparam int MEMB = 256;

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, mosi;
  logic miso, miso_oe;
  int   nchk = 0;
  int   nerr = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  spi_flash_rd_resp u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .miso_oe(miso_oe)
  );

  function automatic logic [7:0] exp_mem(input int a);
    int i;
    i = a % MEMB;
    return 8'(((i * 29 + 60) ^ (i >> 3)) & 255);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] op, input int npre, input logic [31:0] pre,
                      input int nout, input bit m3, output logic [7:0] got [8],
                      output bit oe_pre, output bit oe_any, output bit oe_all,
                      output bit unstable, output bit oe_after);
    int total;
    logic v;
    for (int k = 0; k < 8; k++) got[k] = 8'h00;
    oe_pre = 0; oe_any = 0; oe_all = 1; unstable = 0;
    sclk = m3; tick(4);
    cs_n = 1'b0; tick(8);
    total = 8 + npre + 8 * nout;
    for (int b = 0; b < total; b++) begin
      sclk = 1'b0;
      if (b < 8) mosi = op[7-b];
      else if (b < 8 + npre) mosi = pre[npre-1-(b-8)];
      else mosi = 1'($urandom);
      tick(8);
      v = miso;
      if (b < 8 + npre) begin
        if (miso_oe) oe_pre = 1;
      end else begin
        got[(b-8-npre)/8][7-((b-8-npre)%8)] = v;
        if (miso_oe) oe_any = 1; else oe_all = 0;
      end
      sclk = 1'b1; tick(4);
      if (b >= 8 + npre && miso !== v) unstable = 1;
      tick(4);
    end
    if (!m3) sclk = 1'b0;
    tick(8);
    cs_n = 1'b1; tick(8);
    oe_after = miso_oe;
  endtask

  task automatic run_read(input logic [7:0] op, input int addr, input int n, input bit m3,
                          input string tag);
    logic [7:0] g [8];
    bit p, a, al, u, af;
    logic [31:0] pre;
    int np;
    if (op == 8'h0B) begin np = 32; pre = {addr[23:0], 8'($urandom)}; end
    else begin np = 24; pre = {8'h00, addr[23:0]}; end
    xfer(op, np, pre, n, m3, g, p, a, al, u, af);
    for (int k = 0; k < n; k++)
      chk(g[k] === exp_mem(addr + k), tag, g[k], exp_mem(addr + k));
    chk(al && !p && !af, {tag, " R3 enable"}, {p, al, af}, 3'b010);
    chk(!u, {tag, " R2 stable"}, u, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] g [8];
    bit p, a, al, u, af;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(6);
    chk(miso_oe === 1'b0, "R12 reset enable", miso_oe, 0);

    // R7 identity, mode 0, runs past the last byte
    xfer(8'h9F, 0, 0, 5, 1'b0, g, p, a, al, u, af);
    chk({g[0], g[1], g[2]} === 24'hEF4014, "R7 jedec", {g[0], g[1], g[2]}, 24'hEF4014);
    chk({g[3], g[4]} === 16'hEF40, "R7 repeat", {g[3], g[4]}, 16'hEF40);
    chk(al && !p && !af, "R3 jedec enable", {p, al, af}, 3'b010);
    chk(!u, "R2 jedec stable", u, 0);

    // R8 manufacturer/device, mode 3 (R1)
    xfer(8'h90, 24, 0, 4, 1'b1, g, p, a, al, u, af);
    chk({g[0], g[1], g[2], g[3]} === 32'hEF13EF13, "R8 R1 mfdev mode3",
        {g[0], g[1], g[2], g[3]}, 32'hEF13EF13);

    // R9 device id with filler while awake
    xfer(8'hAB, 24, 32'h00A5A5A5, 3, 1'b0, g, p, a, al, u, af);
    chk({g[0], g[1], g[2]} === 24'h131313, "R9 devid", {g[0], g[1], g[2]}, 24'h131313);

    // R4, R6 wrap at top and aliasing of high address bits
    run_read(8'h03, 254, 4, 1'b0, "R4 R6 wrap");
    run_read(8'h03, 24'h1234FD, 5, 1'b1, "R6 alias");
    // R5 fast read with filler clocks
    run_read(8'h0B, 16, 3, 1'b0, "R5 fast");
    run_read(8'h0B, 255, 2, 1'b1, "R5 R6 fast wrap");

    // R11 unknown opcode
    xfer(8'h55, 0, 0, 2, 1'b0, g, p, a, al, u, af);
    chk(!a && !p && !af, "R11 unknown ignored", {p, a, af}, 0);

    // R10 sleep, then reads and identity are ignored
    xfer(8'hB9, 0, 0, 0, 1'b0, g, p, a, al, u, af);
    xfer(8'h03, 24, 0, 2, 1'b0, g, p, a, al, u, af);
    chk(!a && !p, "R10 read ignored asleep", {p, a}, 0);
    xfer(8'h9F, 0, 0, 3, 1'b1, g, p, a, al, u, af);
    chk(!a && !p, "R10 jedec ignored asleep", {p, a}, 0);
    xfer(8'h90, 24, 0, 2, 1'b0, g, p, a, al, u, af);
    chk(!a, "R10 mfdev ignored asleep", a, 0);
    // R9 wake returns the id and restores service
    xfer(8'hAB, 24, 0, 2, 1'b0, g, p, a, al, u, af);
    chk(al && {g[0], g[1]} === 16'h1313, "R9 wake id", {g[0], g[1]}, 16'h1313);
    run_read(8'h03, 7, 2, 1'b0, "R9 R4 after wake");

    // constrained random reads
    for (int t = 0; t < 30; t++) begin
      logic [7:0] op;
      op = ($urandom % 2) ? 8'h0B : 8'h03;
      run_read(op, int'($urandom & 32'hFFFFFF), 1 + int'($urandom % 6), 1'($urandom),
               (op == 8'h03) ? "R4 R1 random" : "R5 R1 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule